// File: doc/BRIEF.md
# Peripheral Slot Window Decoder with ROM/RAM Banking and Phantom-Slot Trapping

This block sits on an 8-bit host bus with a 16-bit address. It watches the per-slot I/O page of the slot the card occupies. That page is the 256-byte window at `0xC000 + slot*0x100`, for slots 1 to 7. The block steers each access inside the page to one of the card's resources: a banked program ROM, a banked battery-backed scratch RAM, external device registers, or two registers it holds itself. The two internal registers are the bank selector and the trap mask. The block does not use the bus slot-select strobe. Its enables come from its own address compare, so it keeps working while it pulls the shared inhibit line low.

The trap mask holds one bit for each peripheral slot. Suppose a bus cycle addresses the I/O page of another slot whose mask bit is set. The block then drives the active-low inhibit line for that cycle. This silences every other card, and the slot becomes a phantom slot. All enables and `inhibit_n` are combinational from the address and strobe, so they are valid in the same cycle. Register writes take effect at the next rising clock edge.

Top module: `slot_window_decoder`

## Requirements
- R1: When `bus_valid` is low, or the address lies outside the I/O page of `card_slot`, then `rom_ce`, `nvram_ce`, `dev_ce` and `reg_oe` are all low. An I/O page is `addr[15:11]` equal to `5'b11000`, with the slot in `addr[10:8]`.
- R2: An access to the own page at offsets 0x00 to 0xEF raises `rom_ce`. `rom_addr` is then `{rom_bank, addr[7:0]}`, where `rom_bank` is bits 2:0 of the bank register.
- R3: An access to the own page at offsets 0xF0 to 0xF7 raises `nvram_ce`. `nvram_addr` is then `{ram_bank, addr[2:0]}`. `ram_bank` has 5 bits: its MSB is bit 3 of the bank register and its low four bits are bits 7:4.
- R4: An access to the own page at offsets 0xF9, 0xFA, 0xFB, 0xFD, 0xFE or 0xFF raises `dev_ce`, with `dev_sel` equal to `addr[2:0]`.
- R5: A write (`bus_rw`=0) to own offset 0xF8 loads the bank register at the next clock edge. A read (`bus_rw`=1) of 0xF8 raises `reg_oe` and returns the register on `rd_data`.
- R6: A write to own offset 0xFC loads the trap mask at the next clock edge. A read of 0xFC raises `reg_oe` and returns the full byte. Bit n of the mask stands for slot n.
- R7: `inhibit_n` is low exactly when `bus_valid` is high and the address lies in the I/O page of a slot s with 1 ≤ s ≤ 7, s ≠ `card_slot` and mask bit s set. In such a cycle no enable is raised.
- R8: Mask bit 0 and the mask bit of `card_slot` never cause trapping. The own page is still decoded normally when its bit is set.
- R9: After a synchronous reset (`rst_n` low at a clock edge), both the bank register and the trap mask read 0.
- R10: At most one of `rom_ce`, `nvram_ce`, `dev_ce`, `reg_oe` is high in any cycle.
- R11: Reads, and writes to any other offset, leave the bank register and the trap mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_slot | input | 3 | Physical slot of the card, 1 to 7 |
| bus_valid | input | 1 | Host bus cycle in progress |
| bus_addr | input | 16 | Host address |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 8 | Host write data |
| rom_ce | output | 1 | Program ROM enable |
| rom_addr | output | 11 | Banked ROM address |
| nvram_ce | output | 1 | Scratch RAM enable |
| nvram_addr | output | 8 | Banked RAM address |
| dev_ce | output | 1 | External device register enable |
| dev_sel | output | 3 | Device register index |
| reg_oe | output | 1 | Internal register drives read data |
| rd_data | output | 8 | Internal register read data |
| inhibit_n | output | 1 | Shared active-low inhibit line |

## Verification
The bench goes after the region edges 0xEF/0xF0, 0xF7/0xF8 and 0xFB/0xFC/0xFD. A decoder that gets these wrong enables two resources at once, or sends a register access to the ROM. It loads masks that set the card's own bit and bit 0. A design that traps these would lock itself out or inhibit slot 0. It writes bank values whose bit 3 and bits 7:4 differ. A design that mixes up the RAM-bank bit order then shows a wrong `nvram_addr`. Random traffic mixes reads and writes to the register offsets, which exposes registers that load on reads or on neighbouring offsets.

// File: rtl/swd_pkg.sv
// Package: shared types and address-layout constants for the slot window
// decoder. Assumes an 8-bit data bus and 256-byte per-slot I/O pages.
package swd_pkg;

    // Region an access to the card's own page falls into
    typedef enum logic [2:0] {
        RG_NONE,
        RG_ROM,
        RG_NVRAM,
        RG_DEV,
        RG_BANKREG,
        RG_MASKREG
    } region_e;

    localparam int unsigned PAGE_W     = 8;          // offset bits in a page
    localparam logic [7:0]  NVRAM_BASE = 8'hF0;      // first scratch RAM offset
    localparam logic [7:0]  REG_BASE   = 8'hF8;      // first register offset
    localparam logic [2:0]  BANK_IDX   = 3'd0;       // 0xF8 within register block
    localparam logic [2:0]  MASK_IDX   = 3'd4;       // 0xFC within register block

    // Classify an offset inside the own page
    function automatic region_e classify(input logic [7:0] off);
        region_e r;
        if (off < NVRAM_BASE)
            r = RG_ROM;
        else if (off < REG_BASE)
            r = RG_NVRAM;
        else if (off[2:0] == BANK_IDX)
            r = RG_BANKREG;
        else if (off[2:0] == MASK_IDX)
            r = RG_MASKREG;
        else
            r = RG_DEV;
        return r;
    endfunction

endpackage

// File: rtl/swd_region_decode.sv
// Module: swd_region_decode
// Splits the host address into page tag, slot and offset, tells whether the
// access hits the card's own page, and classifies the offset there.
// Assumes the I/O pages sit at the tag IO_TAG in the upper address bits.
module swd_region_decode
    import swd_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SLOT_W = 3,
    parameter logic [ADDR_W-PAGE_W-SLOT_W-1:0] IO_TAG = 5'b11000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              valid,
    input  logic [SLOT_W-1:0] card_slot,
    output logic              in_io,
    output logic [SLOT_W-1:0] slot,
    output logic [7:0]        offset,
    output logic              own_hit,
    output region_e           region
);
    localparam int unsigned SLOT_LSB = PAGE_W;
    localparam int unsigned TAG_LSB  = PAGE_W + SLOT_W;

    // Field extraction and page compare
    always_comb begin
        offset  = addr[PAGE_W-1:0];
        slot    = addr[TAG_LSB-1:SLOT_LSB];
        in_io   = valid && (addr[ADDR_W-1:TAG_LSB] == IO_TAG);
        own_hit = in_io && (slot == card_slot);
    end

    // Offset classification, only inside the own page
    always_comb begin
        region = own_hit ? classify(offset) : RG_NONE;
    end

endmodule

// File: rtl/swd_bank_regs.sv
// Module: swd_bank_regs
// Holds the bank selector and the phantom-slot trap mask. Each loads on its
// write strobe at the clock edge. Unpacks the bank fields: ROM bank in
// bits 2:0, RAM bank MSB in bit 3 and RAM bank low bits in bits 7:4.
// Assumes strobes are already qualified by page, offset and direction.
module swd_bank_regs #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned ROM_BANK_W = 3,
    parameter int unsigned RAM_BANK_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_bank,
    input  logic                  wr_mask,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     bank_q,
    output logic [DATA_W-1:0]     mask_q,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank
);
    localparam int unsigned RAM_LO_W = RAM_BANK_W - 1;
    localparam int unsigned HI_BIT   = ROM_BANK_W;   // bit 3 of the register

    // Bank selector register
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (wr_bank)
            bank_q <= wdata;
    end

    // Trap mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= wdata;
    end

    // Field unpacking
    always_comb begin
        rom_bank = bank_q[ROM_BANK_W-1:0];
        ram_bank = {bank_q[HI_BIT], bank_q[DATA_W-1:DATA_W-RAM_LO_W]};
    end

endmodule

// File: rtl/swd_phantom_trap.sv
// Module: swd_phantom_trap
// Raises trap when the current I/O access addresses the page of a slot,
// other than slot 0 and the card's own slot, whose mask bit is set.
// Assumes one mask bit per slot, bit index equal to slot number.
module swd_phantom_trap #(
    parameter int unsigned SLOT_W = 3
) (
    input  logic                   in_io,
    input  logic [SLOT_W-1:0]      slot,
    input  logic [SLOT_W-1:0]      card_slot,
    input  logic [(1<<SLOT_W)-1:0] mask,
    output logic                   trap
);
    localparam int unsigned NSLOT = 1 << SLOT_W;

    logic [NSLOT-1:0] hit;

    assign hit[0] = 1'b0;   // slot 0 is never trapped

    for (genvar s = 1; s < NSLOT; s++) begin : g_slot
        // Per-slot trap condition
        assign hit[s] = mask[s] && (slot == SLOT_W'(s)) && (card_slot != SLOT_W'(s));
    end

    // Combine per-slot hits for the current access
    always_comb begin
        trap = in_io && (|hit);
    end

endmodule

// File: rtl/slot_window_decoder.sv
// Module: slot_window_decoder (top)
// Decodes the card's 256-byte slot page into ROM, scratch RAM, device and
// internal register accesses. Drives the shared inhibit line for accesses
// to trapped slots. Enables and inhibit are combinational; register writes
// land at the next clock edge. Assumes card_slot is 1..7 and static.
module slot_window_decoder
    import swd_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SLOT_W     = 3,
    parameter int unsigned ROM_BANK_W = 3,
    parameter int unsigned RAM_BANK_W = 5,
    parameter int unsigned RAM_OFF_W  = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SLOT_W-1:0]                card_slot,
    input  logic                             bus_valid,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic                             bus_rw,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic                             rom_ce,
    output logic [ROM_BANK_W+PAGE_W-1:0]     rom_addr,
    output logic                             nvram_ce,
    output logic [RAM_BANK_W+RAM_OFF_W-1:0]  nvram_addr,
    output logic                             dev_ce,
    output logic [2:0]                       dev_sel,
    output logic                             reg_oe,
    output logic [DATA_W-1:0]                rd_data,
    output logic                             inhibit_n
);
    logic                  in_io;
    logic [SLOT_W-1:0]     slot;
    logic [7:0]            offset;
    logic                  own_hit;
    region_e               region;
    logic                  wr_bank;
    logic                  wr_mask;
    logic [DATA_W-1:0]     bank_q;
    logic [DATA_W-1:0]     mask_q;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  trap;

    swd_region_decode #(
        .ADDR_W (ADDR_W),
        .SLOT_W (SLOT_W)
    ) u_decode (
        .addr      (bus_addr),
        .valid     (bus_valid),
        .card_slot (card_slot),
        .in_io     (in_io),
        .slot      (slot),
        .offset    (offset),
        .own_hit   (own_hit),
        .region    (region)
    );

    // Register write strobes
    always_comb begin
        wr_bank = (region == RG_BANKREG) && !bus_rw;
        wr_mask = (region == RG_MASKREG) && !bus_rw;
    end

    swd_bank_regs #(
        .DATA_W     (DATA_W),
        .ROM_BANK_W (ROM_BANK_W),
        .RAM_BANK_W (RAM_BANK_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_bank  (wr_bank),
        .wr_mask  (wr_mask),
        .wdata    (bus_wdata),
        .bank_q   (bank_q),
        .mask_q   (mask_q),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank)
    );

    swd_phantom_trap #(
        .SLOT_W (SLOT_W)
    ) u_trap (
        .in_io     (in_io),
        .slot      (slot),
        .card_slot (card_slot),
        .mask      (mask_q),
        .trap      (trap)
    );

    // Chip enables and resource addresses
    always_comb begin
        rom_ce     = (region == RG_ROM);
        nvram_ce   = (region == RG_NVRAM);
        dev_ce     = (region == RG_DEV);
        reg_oe     = bus_rw && ((region == RG_BANKREG) || (region == RG_MASKREG));
        rom_addr   = {rom_bank, offset};
        nvram_addr = {ram_bank, offset[RAM_OFF_W-1:0]};
        dev_sel    = offset[2:0];
    end

    // Internal register read mux
    always_comb begin
        if (!reg_oe)
            rd_data = '0;
        else if (region == RG_MASKREG)
            rd_data = mask_q;
        else
            rd_data = bank_q;
    end

    // Shared inhibit line, active low
    always_comb begin
        inhibit_n = !trap;
    end

endmodule

// File: rtl/slot_window_decoder_checker.sv
// Module: slot_window_decoder_checker
// Property checks on the decoder, attached to every instance by bind.
module slot_window_decoder_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic [15:0] bus_addr,
    input logic        bus_rw,
    input logic [2:0]  card_slot,
    input logic        rom_ce,
    input logic        nvram_ce,
    input logic        dev_ce,
    input logic        reg_oe,
    input logic        inhibit_n,
    input logic [7:0]  bank_q,
    input logic [7:0]  mask_q
);
    logic own_page;
    assign own_page = bus_valid && (bus_addr[15:11] == 5'b11000) && (bus_addr[10:8] == card_slot);

    a_r10_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_ce, nvram_ce, dev_ce, reg_oe}));

    a_r7_inhibit_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |-> bus_valid);

    a_r7_no_enable_when_trapped: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit_n |-> !(rom_ce || nvram_ce || dev_ce || reg_oe));

    a_r8_own_page_not_trapped: assert property (@(posedge clk) disable iff (!rst_n)
        own_page |-> inhibit_n);

    a_r1_no_enable_off_page: assert property (@(posedge clk) disable iff (!rst_n)
        !own_page |-> !(rom_ce || nvram_ce || dev_ce || reg_oe));

    a_r2_rom_range: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce |-> (bus_addr[7:0] < 8'hF0));

    a_r11_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(own_page && !bus_rw && bus_addr[7:0] == 8'hF8) |=> $stable(bank_q));

    a_r11_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(own_page && !bus_rw && bus_addr[7:0] == 8'hFC) |=> $stable(mask_q));

    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (bank_q == 8'h00 && mask_q == 8'h00));

endmodule

bind slot_window_decoder slot_window_decoder_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_rw    (bus_rw),
    .card_slot (card_slot),
    .rom_ce    (rom_ce),
    .nvram_ce  (nvram_ce),
    .dev_ce    (dev_ce),
    .reg_oe    (reg_oe),
    .inhibit_n (inhibit_n),
    .bank_q    (bank_q),
    .mask_q    (mask_q)
);

// File: tb/slot_window_decoder_tb_top.sv
// Bench: directed corners plus seeded random traffic, checked against a
// model built from the requirements.
module slot_window_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  card_slot = 3'd5;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rw = 1'b1;
    logic [7:0]  bus_wdata = 8'h00;
    logic        rom_ce, nvram_ce, dev_ce, reg_oe, inhibit_n;
    logic [10:0] rom_addr;
    logic [7:0]  nvram_addr, rd_data;
    logic [2:0]  dev_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] m_bank = 8'h00;
    logic [7:0] m_mask = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    slot_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .card_slot(card_slot),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_rw(bus_rw),
        .bus_wdata(bus_wdata), .rom_ce(rom_ce), .rom_addr(rom_addr),
        .nvram_ce(nvram_ce), .nvram_addr(nvram_addr), .dev_ce(dev_ce),
        .dev_sel(dev_sel), .reg_oe(reg_oe), .rd_data(rd_data),
        .inhibit_n(inhibit_n)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h addr=%h rw=%0b", req, act, exp, bus_addr, bus_rw);
        end
    endtask

    function automatic bit f_own(logic v, logic [15:0] a, logic [2:0] cs);
        return v && a[15:11] == 5'b11000 && a[10:8] == cs;
    endfunction

    function automatic bit f_trap(logic v, logic [15:0] a, logic [2:0] cs, logic [7:0] m);
        return v && a[15:11] == 5'b11000 && a[10:8] != 3'd0 && a[10:8] != cs && m[a[10:8]];
    endfunction

    // One bus cycle: drive after an edge, check mid-cycle, update model on the next edge
    task automatic bus_cycle(logic v, logic [15:0] a, logic rw, logic [7:0] wd);
        bit own, trp;
        logic [7:0] off;
        bus_valid = v; bus_addr = a; bus_rw = rw; bus_wdata = wd;
        #3;
        own = f_own(v, a, card_slot);
        trp = f_trap(v, a, card_slot, m_mask);
        off = a[7:0];
        check("R7 inhibit", inhibit_n, !trp);
        check("R2 rom_ce", rom_ce, own && off < 8'hF0);
        check("R3 nvram_ce", nvram_ce, own && off >= 8'hF0 && off < 8'hF8);
        check("R4 dev_ce", dev_ce, own && off >= 8'hF8 && off != 8'hF8 && off != 8'hFC);
        check("R5/R6 reg_oe", reg_oe, own && rw && (off == 8'hF8 || off == 8'hFC));
        check("R10 one enable", $countones({rom_ce, nvram_ce, dev_ce, reg_oe}) <= 1, 1);
        if (own && off < 8'hF0)
            check("R2 rom_addr", rom_addr, {m_bank[2:0], off});
        if (own && off >= 8'hF0 && off < 8'hF8)
            check("R3 nvram_addr", nvram_addr, {m_bank[3], m_bank[7:4], off[2:0]});
        if (own && off >= 8'hF8 && off != 8'hF8 && off != 8'hFC)
            check("R4 dev_sel", dev_sel, off[2:0]);
        if (own && rw && off == 8'hF8)
            check("R5 bank read", rd_data, m_bank);
        if (own && rw && off == 8'hFC)
            check("R6 mask read", rd_data, m_mask);
        @(posedge clk);
        if (own && !rw && off == 8'hF8) m_bank = wd;
        if (own && !rw && off == 8'hFC) m_mask = wd;
        #1;
    endtask

    function automatic logic [15:0] pg(logic [2:0] s, logic [7:0] off);
        return {5'b11000, s, off};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9: reset state
        bus_cycle(1, pg(5, 8'hF8), 1, 0);
        bus_cycle(1, pg(5, 8'hFC), 1, 0);
        bus_cycle(1, pg(3, 8'h10), 1, 0);
        // R1: idle strobe and foreign addresses
        bus_cycle(0, pg(5, 8'h20), 1, 0);
        bus_cycle(1, 16'hC800, 1, 0);
        bus_cycle(1, 16'h0500, 1, 0);
        // R2/R3/R4 boundaries
        bus_cycle(1, pg(5, 8'hEF), 1, 0);
        bus_cycle(1, pg(5, 8'hF0), 1, 0);
        bus_cycle(1, pg(5, 8'hF7), 1, 0);
        bus_cycle(1, pg(5, 8'hFB), 1, 0);
        bus_cycle(1, pg(5, 8'hFD), 1, 0);
        bus_cycle(1, pg(5, 8'hFF), 1, 0);
        // R5: bank with split RAM fields
        bus_cycle(1, pg(5, 8'hF8), 0, 8'hA6);
        bus_cycle(1, pg(5, 8'hF8), 1, 0);
        bus_cycle(1, pg(5, 8'h00), 1, 0);
        bus_cycle(1, pg(5, 8'hF3), 1, 0);
        bus_cycle(1, pg(5, 8'hF8), 0, 8'h5B);
        bus_cycle(1, pg(5, 8'hF5), 0, 8'h00);
        // R11: reads and neighbour writes leave registers alone
        bus_cycle(1, pg(5, 8'hF9), 0, 8'hFF);
        bus_cycle(1, pg(5, 8'hFD), 0, 8'hFF);
        bus_cycle(1, pg(2, 8'hF8), 0, 8'hFF);
        bus_cycle(1, pg(5, 8'hF8), 1, 0);
        bus_cycle(1, pg(5, 8'hFC), 1, 0);
        // R6/R7/R8: mask with bit 0 and own bit set
        bus_cycle(1, pg(5, 8'hFC), 0, 8'b1010_0101);
        bus_cycle(1, pg(5, 8'hFC), 1, 0);
        bus_cycle(1, pg(2, 8'h40), 1, 0);
        bus_cycle(1, pg(7, 8'hFF), 0, 8'h11);
        bus_cycle(1, pg(3, 8'h40), 1, 0);
        bus_cycle(1, pg(0, 8'h40), 1, 0);
        bus_cycle(1, pg(5, 8'h40), 1, 0);
        bus_cycle(0, pg(2, 8'h40), 1, 0);
        // R9: reset mid-run
        rst_n = 1'b0; @(posedge clk); #1 rst_n = 1'b1;
        m_bank = 8'h00; m_mask = 8'h00;
        bus_cycle(1, pg(5, 8'hF8), 1, 0);
        bus_cycle(1, pg(5, 8'hFC), 1, 0);
        bus_cycle(1, pg(2, 8'h40), 1, 0);
        // Random traffic, two card positions
        void'($urandom(32'd1234));
        for (int ph = 0; ph < 2; ph++) begin
            card_slot = (ph == 0) ? 3'd5 : 3'd1;
            for (int i = 0; i < 3000; i++) begin
                logic [15:0] a;
                logic [7:0] off;
                int sel;
                sel = $urandom % 8;
                off = ($urandom % 2) ? 8'hF0 + 8'($urandom % 16) : 8'($urandom);
                if (sel < 5) a = pg(card_slot, off);
                else if (sel < 7) a = pg(3'($urandom), off);
                else a = 16'($urandom);
                bus_cycle(($urandom % 8) != 0, a, $urandom % 2, 8'($urandom));
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule